// File: doc/BRIEF.md
# UART Interrupt Source Identifier and Prioritizer

This block sits beside the receive and transmit paths of a UART that can run either with FIFOs or with single holding registers. It watches four interrupt conditions (receive line errors, received data ready, receive character timeout and transmitter empty), drops the ones whose enable bit is clear, and reports the most urgent of the rest as a 3-bit code inside an 8-bit read-only identification value. When any enabled condition is pending, it also drives a single interrupt request line.

The receive character-timeout detector is part of the block. It counts character-time ticks while the receive FIFO holds data and nothing moves in or out of it. Every source has its own clearing rule, tied to bus strobes: a line-status read, a receive-buffer read, a holding-register write or an identification read. The FIFOs, the shift registers and the baud generator are outside the block and appear only as status inputs.

Top module: `uart_irq_id`

## Requirements
- R1: While reset is asserted and right after it, `id_value` reads 8'h01 (code 000, bit 0 high, bits 7:6 at 00) and `irq` is low.
- R2: Bits 7:6 of `id_value` read 11 when `fifo_en` is 1 and 00 when it is 0. Bits 5:4 always read 0.
- R3: A high bit in `lsr_err` (overrun, parity, framing or break, in any bit order) makes the line-error source pending, and it stays pending until a cycle in which `lsr_rd` is high and no `lsr_err` bit is high. Its code is 011.
- R4: The data-ready source (code 010) is pending when `rx_level` is nonzero with `fifo_en`=0, or when `rx_level` >= `rx_trig` with `fifo_en`=1. It goes away as soon as the level no longer meets that condition.
- R5: Timeout (code 110) appears in the cycle after the fourth clock edge at which `char_tick` is high, counting only while `fifo_en`=1, `rx_level` is nonzero, and there has been no `rx_push` or `rbr_rd`. A push or a receive-buffer read clears it and starts the count again. The count stays at zero while the FIFO is empty or FIFO mode is off, and it saturates at the limit.
- R6: The transmitter-empty source (code 001) arms on a 0-to-1 transition of `tx_empty` (`tx_empty` high at reset does not arm it). It is cleared by `thr_wr`, or by `id_rd` only in a cycle when the reported code is 001. A new transition is needed to arm it again.
- R7: The fixed priority order is 011, then 010, then 110, then 001. When 010 and 110 are both pending and enabled, 010 is reported.
- R8: `ien` bit 0 enables transmitter empty, bit 1 data ready, bit 2 line error and bit 3 timeout. A source whose enable bit is clear is left out of the selection, so a lower enabled source is reported in its place. `irq` is high exactly when the reported code is not 000.
- R9: Bit 0 of `id_value` is 1 when the reported code is 000 and 0 otherwise. Bits 3:1 carry the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 selects FIFO mode |
| lsr_err | input | 4 | Line error flags (overrun, parity, framing, break) |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger threshold |
| tx_empty | input | 1 | Transmit FIFO or holding register empty |
| ien | input | 4 | Per-source interrupt enables |
| char_tick | input | 1 | One pulse per character time |
| rx_push | input | 1 | A character was written into the receive FIFO |
| rbr_rd | input | 1 | Receive buffer read strobe (pops the FIFO) |
| lsr_rd | input | 1 | Line status read strobe |
| id_rd | input | 1 | Identification value read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| id_value | output | 8 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 3-bit FIFO level and a four-character timeout. With these values every pairing of fill level and trigger, in both FIFO and non-FIFO mode, can be swept in full. It also sweeps all sixteen enable masks against two fixed sets of pending sources, one with data ready absent and one with it present. Because the timeout limit is small, the bench can walk the count tick by tick and reach the edge cases of R5 and R6 in a few cycles: saturation, restart on a push, holding while empty, and a set arriving in the same cycle as a clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        CODE_NONE = 3'b000,
        CODE_TXE  = 3'b001,
        CODE_RXD  = 3'b010,
        CODE_LINE = 3'b011,
        CODE_TMO  = 3'b110
    } irq_code_e;

    typedef struct packed {
        logic line;
        logic rxd;
        logic tmo;
        logic txe;
    } irq_src_t;

    localparam int EN_TXE  = 0;
    localparam int EN_RXD  = 1;
    localparam int EN_LINE = 2;
    localparam int EN_TMO  = 3;
    localparam int EN_W    = 4;

    function automatic logic [7:0] pack_id(logic fifo, irq_code_e c);
        return {{2{fifo}}, 2'b00, c, (c == CODE_NONE)};
    endfunction

endpackage

// File: rtl/uirq_timeout.sv
module uirq_timeout
    import uart_irq_pkg::*;
#(
    parameter int LVL_W      = 3,
    parameter int CHAR_TIMES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             char_tick,
    output logic             tmo_pend
);
    localparam int CNT_W = $clog2(CHAR_TIMES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CHAR_TIMES);

    logic [CNT_W-1:0] cnt;
    logic             hold;

    assign hold = !fifo_en || (rx_level == '0);

    always_ff @(posedge clk) begin
        if (rst || hold || rx_push || rx_pop)
            cnt <= '0;
        else if (char_tick && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign tmo_pend = (cnt == LIMIT);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        hold |=> !tmo_pend);
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_push || rx_pop) |=> !tmo_pend);

endmodule

// File: rtl/uirq_sources.sv
module uirq_sources
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [ERR_W-1:0] lsr_err,
    input  logic             lsr_rd,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             tx_empty,
    input  logic             thr_wr,
    input  logic             id_rd,
    input  logic             rep_txe,
    output logic             line_pend,
    output logic             rxd_pend,
    output logic             txe_pend
);
    logic tx_empty_q;
    logic tx_rise;

    assign tx_rise = tx_empty && !tx_empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_pend  <= 1'b0;
            txe_pend   <= 1'b0;
            tx_empty_q <= 1'b1;
        end else begin
            tx_empty_q <= tx_empty;
            if (|lsr_err)
                line_pend <= 1'b1;
            else if (lsr_rd)
                line_pend <= 1'b0;
            if (tx_rise)
                txe_pend <= 1'b1;
            else if (thr_wr || (id_rd && rep_txe))
                txe_pend <= 1'b0;
        end
    end

    assign rxd_pend = fifo_en ? (rx_level >= rx_trig) : (rx_level != '0);

    p_line_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !(|lsr_err)) |=> !line_pend);
    p_line_set_r3: assert property (@(posedge clk) disable iff (rst)
        (|lsr_err) |=> line_pend);
    p_tx_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !tx_empty) |=> !txe_pend);
    p_tx_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (txe_pend && !thr_wr && !(id_rd && rep_txe)) |=> txe_pend);

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  irq_src_t        src,
    input  logic [EN_W-1:0] ien,
    output irq_code_e       code,
    output logic            irq
);
    always_comb begin
        if (src.line && ien[EN_LINE])
            code = CODE_LINE;
        else if (src.rxd && ien[EN_RXD])
            code = CODE_RXD;
        else if (src.tmo && ien[EN_TMO])
            code = CODE_TMO;
        else if (src.txe && ien[EN_TXE])
            code = CODE_TXE;
        else
            code = CODE_NONE;
    end

    assign irq = (code != CODE_NONE);

    p_top_line_r7: assert property (@(posedge clk) disable iff (rst)
        (src.line && ien[EN_LINE]) |-> code == CODE_LINE);
    p_lvl2_order_r7: assert property (@(posedge clk) disable iff (rst)
        (!(src.line && ien[EN_LINE]) && src.rxd && ien[EN_RXD]) |-> code == CODE_RXD);
    p_mask_tmo_r8: assert property (@(posedge clk) disable iff (rst)
        (code == CODE_TMO) |-> (ien[EN_TMO] && src.tmo));
    p_mask_txe_r8: assert property (@(posedge clk) disable iff (rst)
        (code == CODE_TXE) |-> (ien[EN_TXE] && src.txe));

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int LVL_W      = 3,
    parameter int CHAR_TIMES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  logic [3:0]       lsr_err,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trig,
    input  logic             tx_empty,
    input  logic [3:0]       ien,
    input  logic             char_tick,
    input  logic             rx_push,
    input  logic             rbr_rd,
    input  logic             lsr_rd,
    input  logic             id_rd,
    input  logic             thr_wr,
    output logic [7:0]       id_value,
    output logic             irq
);
    irq_src_t  src;
    irq_code_e code;
    logic      line_pend, rxd_pend, txe_pend, tmo_pend;

    uirq_sources #(.LVL_W(LVL_W), .ERR_W(4)) u_src (
        .clk(clk), .rst(rst), .fifo_en(fifo_en),
        .lsr_err(lsr_err), .lsr_rd(lsr_rd),
        .rx_level(rx_level), .rx_trig(rx_trig),
        .tx_empty(tx_empty), .thr_wr(thr_wr), .id_rd(id_rd),
        .rep_txe(code == CODE_TXE),
        .line_pend(line_pend), .rxd_pend(rxd_pend), .txe_pend(txe_pend)
    );

    uirq_timeout #(.LVL_W(LVL_W), .CHAR_TIMES(CHAR_TIMES)) u_tmo (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_level(rx_level),
        .rx_push(rx_push), .rx_pop(rbr_rd), .char_tick(char_tick),
        .tmo_pend(tmo_pend)
    );

    assign src = '{line: line_pend, rxd: rxd_pend, tmo: tmo_pend, txe: txe_pend};

    uirq_prio u_prio (
        .clk(clk), .rst(rst), .src(src), .ien(ien),
        .code(code), .irq(irq)
    );

    assign id_value = pack_id(fifo_en, code);

    p_id_mode_r2: assert property (@(posedge clk) disable iff (rst)
        id_value[7:4] == (fifo_en ? 4'b1100 : 4'b0000));
    p_idle_bit_r9: assert property (@(posedge clk) disable iff (rst)
        id_value[0] == !irq);

endmodule

// File: tb/uart_irq_id_test.sv
module uart_irq_id_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       fifo_en;
    logic [3:0] lsr_err;
    logic [2:0] rx_level, rx_trig;
    logic       tx_empty;
    logic [3:0] ien;
    logic       char_tick, rx_push, rbr_rd, lsr_rd, id_rd, thr_wr;
    logic [7:0] id_value;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_irq_id #(.LVL_W(3), .CHAR_TIMES(4)) uut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .lsr_err(lsr_err),
        .rx_level(rx_level), .rx_trig(rx_trig), .tx_empty(tx_empty),
        .ien(ien), .char_tick(char_tick), .rx_push(rx_push),
        .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .id_rd(id_rd), .thr_wr(thr_wr),
        .id_value(id_value), .irq(irq)
    );

    function automatic logic [7:0] exp_id(logic f, logic [2:0] c);
        return {f, f, 2'b00, c, (c == 3'b000)};
    endfunction

    function automatic logic [2:0] exp_code(logic l, logic r, logic t, logic x, logic [3:0] e);
        if (l && e[2]) return 3'b011;
        if (r && e[1]) return 3'b010;
        if (t && e[3]) return 3'b110;
        if (x && e[0]) return 3'b001;
        return 3'b000;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_id(string req, logic [2:0] c);
        chk(req, id_value, exp_id(fifo_en, c));
        chk(req, {7'b0, irq}, {7'b0, (c != 3'b000)});
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            char_tick = 1'b1;
            step();
            char_tick = 1'b0;
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fifo_en = 0; lsr_err = 0; rx_level = 0; rx_trig = 1;
        tx_empty = 1'b1; ien = 4'hF; char_tick = 0; rx_push = 0;
        rbr_rd = 0; lsr_rd = 0; id_rd = 0; thr_wr = 0;
        step(); step();
        // R1 reset value, tx_empty high at reset must not arm
        chk("R1", id_value, 8'h01);
        chk("R1", {7'b0, irq}, 8'h00);
        rst = 1'b0;
        step(); step();
        chk("R1", id_value, 8'h01);

        // R4 / R2 / R9 sweep of level and trigger in both modes
        ien = 4'b0010;
        for (int f = 0; f < 2; f++)
            for (int t = 1; t < 8; t++)
                for (int l = 0; l < 8; l++) begin
                    fifo_en = f[0]; rx_trig = t[2:0]; rx_level = l[2:0];
                    #1;
                    chk_id("R4", ((f == 1) ? (l >= t) : (l != 0)) ? 3'b010 : 3'b000);
                end
        rx_level = 0;
        step();

        // R3 line errors, each bit alone
        fifo_en = 1; ien = 4'b0100;
        for (int b = 0; b < 4; b++) begin
            lsr_err = 4'b0001 << b;
            step();
            lsr_err = 0;
            chk_id("R3", 3'b011);
            lsr_rd = 1; step(); lsr_rd = 0;
            chk_id("R3", 3'b000);
        end
        // R3 new error during the status read keeps it pending
        lsr_err = 4'b0100; step(); lsr_err = 0;
        lsr_rd = 1; lsr_err = 4'b0001; step(); lsr_err = 0; lsr_rd = 0;
        chk_id("R3", 3'b011);
        lsr_rd = 1; step(); lsr_rd = 0;
        chk_id("R3", 3'b000);

        // R5 timeout counting
        ien = 4'b1000; rx_trig = 4; rx_level = 1;
        ticks(3);
        chk_id("R5", 3'b000);
        ticks(1);
        chk_id("R5", 3'b110);
        ticks(3);
        chk_id("R5", 3'b110);      // saturates
        rx_push = 1; step(); rx_push = 0;
        chk_id("R5", 3'b000);
        ticks(3);
        chk_id("R5", 3'b000);
        ticks(1);
        chk_id("R5", 3'b110);
        rbr_rd = 1; step(); rbr_rd = 0;
        chk_id("R5", 3'b000);
        rx_level = 0; ticks(6);
        chk_id("R5", 3'b000);      // held while empty
        rx_level = 1; fifo_en = 0; ticks(6);
        chk_id("R5", 3'b000);      // held in non-FIFO mode
        rx_level = 0; fifo_en = 1; step();

        // R6 transmitter empty
        ien = 4'b0001; tx_empty = 0; step();
        chk_id("R6", 3'b000);
        tx_empty = 1; step();
        chk_id("R6", 3'b001);
        id_rd = 1; step(); id_rd = 0;
        chk_id("R6", 3'b000);
        step(); step();
        chk_id("R6", 3'b000);      // no re-arm while still empty
        tx_empty = 0; step(); tx_empty = 1; step();
        chk_id("R6", 3'b001);
        thr_wr = 1; tx_empty = 0; step(); thr_wr = 0;
        chk_id("R6", 3'b000);
        tx_empty = 1; step();
        ien = 4'b0101; lsr_err = 4'b1000; step(); lsr_err = 0;
        chk_id("R6", 3'b011);
        id_rd = 1; step(); id_rd = 0;   // returned 011: tx stays armed
        lsr_rd = 1; step(); lsr_rd = 0;
        chk_id("R6", 3'b001);

        // R7 / R8 enable sweep: line, timeout, tx pending; data ready off then on
        rx_trig = 3; rx_level = 2;
        lsr_err = 4'b0010; step(); lsr_err = 0;
        ticks(4);
        for (int p = 0; p < 2; p++) begin
            rx_trig = (p == 0) ? 3'd3 : 3'd1;
            for (int m = 0; m < 16; m++) begin
                ien = m[3:0];
                #1;
                chk_id((p == 0) ? "R8" : "R7", exp_code(1'b1, p[0], 1'b1, 1'b1, m[3:0]));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule